// File: doc/BRIEF.md
# Boot Strap Capture and Soft Reboot Controller

This block records a 16-bit bus of configuration pads once, right after power-on reset is released. From that sample it builds a 32-bit configuration word. Groups of fields in the word choose the bus and CPU clock source and divider, the flash and SRAM modes, the CPU reset and cache options, and seven 2-bit clock-skew selects. If the top pad bit is high, the pads are ignored and a built-in 15-bit default is used in their place.

Software reaches the block through a small register port with three readable registers: the raw pad sample, the sticky word, and the system word currently in force. Software can write the sticky word. If that write has the reboot-request bit set, the block asserts its system reset output for a fixed number of cycles. The written word then becomes the system word, so the new configuration survives the reboot. The pads are not sampled again.

The active system word also drives a per-domain skew word. Each 4-bit nibble of that word is a base value shifted according to its 2-bit skew select.

Top module: `strap_boot_ctrl`

## Requirements
- R1: While `rst` is high, `sys_rst_o` is 1 and `reg_rdata_o`, `skew_sel_o` and `skew_cfg_o` are 0. On the first rising clock edge with `rst` low, `sys_rst_o` falls to 0.
- R2: The pad bus is sampled once, on the first rising edge after `rst` falls. Register address 0 returns the 16 sampled bits, zero-extended, no matter how the pads change later.
- R3: If sampled pad bit 15 is 1, the parameter `DEFAULT_STRAP` takes the place of pad bits [14:0] when the configuration word is built. Address 0 still returns the real pad sample.
- R4: With s as the selected 15-bit value, the boot configuration word is laid out as follows:
  - [1:0] = s[1:0], [3:2] = s[3:2], [5:4] = s[1:0] and [7:6] = s[3:2].
  - [8] = s[4], [9] = s[5], [11:10] = s[7:6], [12] = s[8], [13] = s[9] and [14] = s[10].
  - [15] = 0.
  - Each of the seven 2-bit fields in [29:16] equals s[12:11].
  - [31:30] = 0.
  - After boot, both address 1 (sticky) and address 2 (system) return this word.
- R5: A write to address 1 stores the data. Address 1 then reads back the written value with bit 31 forced to 0.
- R6: A write to address 1 with data bit 15 set starts a reboot. `sys_rst_o` is 1 from the next cycle, and address 2 returns the full written word, bit 31 included. A write with bit 15 clear leaves `sys_rst_o` and address 2 unchanged.
- R7: A soft reboot holds `sys_rst_o` high for exactly `HOLD_CYCLES` (default 16) clock cycles.
- R8: Each qualifying write starts only one reboot. Bit 15 stays set in the sticky register but does not start another reboot. A reboot does not sample the pads again.
- R9: Skew nibble i, for i from 0 to 6, is `SKEW_BASE[4i+3:4i]` plus an offset, taken modulo 16. The offset depends on the system-word field at [17+2i:16+2i]: 00 adds 0, 01 adds 2, 10 adds 4 and 11 subtracts 4.
  - `skew_cfg_o[31:28]` is always 0.
  - `skew_cfg_o` follows the system word with a delay of one cycle.
  - `skew_sel_o` is system-word bits [17:16].
- R10: While `sys_rst_o` is high, writes are ignored. Writes to any address other than 1 are also ignored.
- R11: Reads have a latency of one cycle: `reg_rdata_o` reflects the address presented at the previous rising edge. Address 3 and every address above it read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pad_strap_i | input | 16 | Configuration pad bus |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| sys_rst_o | output | 1 | System reset to downstream domains |
| skew_sel_o | output | 2 | First-domain skew select |
| skew_cfg_o | output | 32 | Per-domain skew nibbles |

## Verification
The hardest condition to reach is a second reboot request arriving while the first reboot is still in progress, because the request bit is still held in the sticky register at that time. The bench starts a reboot and writes again in the middle of the reset window. It then counts the reset cycles at the output and reads back the sticky word afterwards. Pads are changed after capture and around each reboot, and address 0 is checked to confirm that no new sample was taken.

// File: rtl/strap_boot_pkg.sv
package strap_boot_pkg;
  localparam int WORD_W      = 32;
  localparam int PAD_W       = 16;
  localparam int SEL_W       = 15;
  localparam int REBOOT_BIT  = 15;
  localparam int SKEW_LSB    = 16;
  localparam int SKEW_FIELDS = 7;
  localparam int NIB_W       = 4;

  typedef enum logic [1:0] {
    RSEL_PAD    = 2'd0,
    RSEL_STICKY = 2'd1,
    RSEL_SYSTEM = 2'd2,
    RSEL_NONE   = 2'd3
  } rsel_e;

  // Spread the selected strap bits over the configuration word.
  function automatic logic [WORD_W-1:0] spread_strap(input logic [12:0] s);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[1:0]   = s[1:0];
    w[3:2]   = s[3:2];
    w[5:4]   = s[1:0];
    w[7:6]   = s[3:2];
    w[8]     = s[4];
    w[9]     = s[5];
    w[11:10] = s[7:6];
    w[12]    = s[8];
    w[13]    = s[9];
    w[14]    = s[10];
    for (int k = 0; k < SKEW_FIELDS; k++) begin
      w[SKEW_LSB + 2*k +: 2] = s[12:11];
    end
    return w;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int PAD_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PAD_W-1:0] pad_i,
  output logic [PAD_W-1:0] pad_q,
  output logic             cap_pulse,
  output logic             booted
);
  // The single capture cycle is the first one after reset with no sample taken.
  assign cap_pulse = !booted;

  always_ff @(posedge clk) begin
    if (rst) begin
      booted <= 1'b0;
      pad_q  <= '0;
    end else if (cap_pulse) begin
      booted <= 1'b1;
      pad_q  <= pad_i;
    end
  end
endmodule

// File: rtl/reboot_seq.sv
module reboot_seq #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_pulse,
  input  logic start,
  output logic sys_rst_o
);
  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_o <= 1'b1;
      run_q     <= 1'b0;
      cnt_q     <= '0;
    end else if (cap_pulse) begin
      sys_rst_o <= 1'b0;
    end else if (start) begin
      sys_rst_o <= 1'b1;
      run_q     <= 1'b1;
      cnt_q     <= LAST;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        sys_rst_o <= 1'b0;
        run_q     <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/skew_gen.sv
module skew_gen #(
  parameter int          FIELDS = 7,
  parameter int          NIB_W  = 4,
  parameter int          OUT_W  = 32,
  parameter logic [27:0] BASE   = 28'h7654321
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*FIELDS-1:0] sel_i,
  output logic [OUT_W-1:0]    skew_o
);
  localparam int USED_W = FIELDS * NIB_W;

  logic [USED_W-1:0] nib_d;

  for (genvar g = 0; g < FIELDS; g++) begin : g_nib
    logic [NIB_W-1:0] base_n;
    assign base_n = BASE[g*NIB_W +: NIB_W];
    always_comb begin
      unique case (sel_i[2*g +: 2])
        2'b00:   nib_d[g*NIB_W +: NIB_W] = base_n;
        2'b01:   nib_d[g*NIB_W +: NIB_W] = base_n + NIB_W'(2);
        2'b10:   nib_d[g*NIB_W +: NIB_W] = base_n + NIB_W'(4);
        default: nib_d[g*NIB_W +: NIB_W] = base_n - NIB_W'(4);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) skew_o <= '0;
    else     skew_o <= {{(OUT_W-USED_W){1'b0}}, nib_d};
  end
endmodule

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl
  import strap_boot_pkg::*;
#(
  parameter int          HOLD_CYCLES   = 16,
  parameter logic [14:0] DEFAULT_STRAP = 15'h1A5B,
  parameter logic [27:0] SKEW_BASE     = 28'h7654321,
  parameter int          ADDR_W        = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       pad_strap_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sys_rst_o,
  output logic [1:0]        skew_sel_o,
  output logic [31:0]       skew_cfg_o
);
  localparam logic [ADDR_W-1:0] A_PAD    = ADDR_W'(RSEL_PAD);
  localparam logic [ADDR_W-1:0] A_STICKY = ADDR_W'(RSEL_STICKY);
  localparam logic [ADDR_W-1:0] A_SYSTEM = ADDR_W'(RSEL_SYSTEM);

  logic [PAD_W-1:0]    pad_q;
  logic                cap_pulse;
  logic                booted;
  logic [WORD_W-2:0]   sticky_q;
  logic [WORD_W-1:0]   system_q;
  logic [12:0]         sel_bits;
  logic                wr_ok;
  logic                reboot_go;

  strap_latch #(.PAD_W(PAD_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .pad_i     (pad_strap_i),
    .pad_q     (pad_q),
    .cap_pulse (cap_pulse),
    .booted    (booted)
  );

  // Override bit swaps in the built-in default.
  assign sel_bits  = pad_strap_i[PAD_W-1] ? DEFAULT_STRAP[12:0] : pad_strap_i[12:0];
  assign wr_ok     = reg_wr_i && booted && !sys_rst_o && (reg_addr_i == A_STICKY);
  assign reboot_go = wr_ok && reg_wdata_i[REBOOT_BIT];

  reboot_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_reboot (
    .clk       (clk),
    .rst       (rst),
    .cap_pulse (cap_pulse),
    .start     (reboot_go),
    .sys_rst_o (sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      system_q <= '0;
    end else if (cap_pulse) begin
      sticky_q <= spread_strap(sel_bits)[WORD_W-2:0];
      system_q <= spread_strap(sel_bits);
    end else if (wr_ok) begin
      sticky_q <= reg_wdata_i[WORD_W-2:0];
      if (reboot_go) system_q <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata_o <= '0;
    end else begin
      if (reg_addr_i == A_PAD)         reg_rdata_o <= {{(WORD_W-PAD_W){1'b0}}, pad_q};
      else if (reg_addr_i == A_STICKY) reg_rdata_o <= {1'b0, sticky_q};
      else if (reg_addr_i == A_SYSTEM) reg_rdata_o <= system_q;
      else                             reg_rdata_o <= '0;
    end
  end

  skew_gen #(
    .FIELDS (SKEW_FIELDS),
    .NIB_W  (NIB_W),
    .OUT_W  (WORD_W),
    .BASE   (SKEW_BASE)
  ) u_skew (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (system_q[SKEW_LSB +: 2*SKEW_FIELDS]),
    .skew_o (skew_cfg_o)
  );

  assign skew_sel_o = system_q[SKEW_LSB +: 2];
endmodule

// File: rtl/strap_boot_ctrl_chk.sv
module strap_boot_ctrl_chk #(
  parameter int HOLD_CYCLES = 16,
  parameter int ADDR_W      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              sys_rst_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 2) + 1;

  logic [CW-1:0] hi_cnt_q;
  logic          prev_q;
  logic          soft_q;
  logic          boot_req;

  assign boot_req = reg_wr_i && (reg_addr_i == ADDR_W'(1)) && reg_wdata_i[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q <= '0;
      prev_q   <= 1'b1;
      soft_q   <= 1'b0;
    end else begin
      prev_q   <= sys_rst_o;
      hi_cnt_q <= sys_rst_o ? hi_cnt_q + 1'b1 : '0;
      if (sys_rst_o && !prev_q) soft_q <= 1'b1;
    end
  end

  p_rst_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(boot_req));

  p_rst_len_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(sys_rst_o) && soft_q) |-> (hi_cnt_q == CW'(HOLD_CYCLES)));

  p_rst_bound_r7: assert property (@(posedge clk) disable iff (rst)
    hi_cnt_q <= CW'(HOLD_CYCLES));

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (rst)
    (!sys_rst_o && !boot_req) |=> !sys_rst_o);

  p_sticky_msb_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr_i) == ADDR_W'(1)) |-> (reg_rdata_o[31] == 1'b0));

  p_unused_addr_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr_i) >= ADDR_W'(3)) |-> (reg_rdata_o == 32'h0));
endmodule

bind strap_boot_ctrl strap_boot_ctrl_chk #(
  .HOLD_CYCLES (HOLD_CYCLES),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .sys_rst_o   (sys_rst_o)
);

// File: tb/strap_boot_ctrl_tb_top.sv
`timescale 1ns/1ps
module strap_boot_ctrl_tb_top;
  localparam int          HOLD = 16;
  localparam logic [14:0] DEF  = 15'h1A5B;
  localparam logic [27:0] SKB  = 28'h7654321;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pad = 16'h0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        sys_rst;
  logic [1:0]  skew_sel;
  logic [31:0] skew_cfg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  strap_boot_ctrl #(
    .HOLD_CYCLES (HOLD),
    .DEFAULT_STRAP (DEF),
    .SKEW_BASE (SKB),
    .ADDR_W (2)
  ) dut_i (
    .clk (clk), .rst (rst), .pad_strap_i (pad),
    .reg_wr_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .sys_rst_o (sys_rst),
    .skew_sel_o (skew_sel), .skew_cfg_o (skew_cfg)
  );

  // Reference model built from the requirement text.
  function automatic logic [31:0] exp_word(input logic [15:0] p);
    logic [14:0] s;
    logic [31:0] w;
    s = p[15] ? DEF : p[14:0];
    w = 32'h0;
    w[1:0] = s[1:0]; w[3:2] = s[3:2]; w[5:4] = s[1:0]; w[7:6] = s[3:2];
    w[8] = s[4]; w[9] = s[5]; w[11:10] = s[7:6]; w[12] = s[8];
    w[13] = s[9]; w[14] = s[10];
    for (int k = 0; k < 7; k++) w[16+2*k +: 2] = s[12:11];
    return w;
  endfunction

  function automatic logic [31:0] exp_skew(input logic [31:0] sys);
    logic [31:0] r;
    logic [3:0]  b;
    r = 32'h0;
    for (int k = 0; k < 7; k++) begin
      b = SKB[4*k +: 4];
      case (sys[16+2*k +: 2])
        2'b00: r[4*k +: 4] = b;
        2'b01: r[4*k +: 4] = b + 4'd2;
        2'b10: r[4*k +: 4] = b + 4'd4;
        default: r[4*k +: 4] = b - 4'd4;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic boot(input logic [15:0] p);
    @(negedge clk); rst = 1'b1; pad = p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; addr = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1", "sys_rst during reset", {31'h0, sys_rst}, 32'h1);
    chk("R1", "rdata during reset", rdata, 32'h0);
    chk("R1", "skew during reset", skew_cfg, 32'h0);
    chk("R1", "skew_sel during reset", {30'h0, skew_sel}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "sys_rst released", {31'h0, sys_rst}, 32'h0);
  endtask

  task automatic t_capture(input logic [15:0] p, input string req);
    logic [31:0] d;
    boot(p);
    chk(req, "release after boot", {31'h0, sys_rst}, 32'h0);
    rd(2'd0, d); chk(req, "raw pad", d, {16'h0, p});
    rd(2'd1, d); chk(req, "sticky word R4", d, exp_word(p));
    rd(2'd2, d); chk(req, "system word R4", d, exp_word(p));
    chk("R9", "skew word", skew_cfg, exp_skew(exp_word(p)));
    chk("R9", "skew select", {30'h0, skew_sel}, {30'h0, exp_word(p)[17:16]});
  endtask

  task automatic t_once;
    logic [31:0] d;
    boot(16'h0A3C);
    pad = 16'hFFFF;
    repeat (4) @(negedge clk);
    rd(2'd0, d); chk("R2", "pad not resampled", d, 32'h0000_0A3C);
    rd(2'd1, d); chk("R2", "sticky not resampled", d, exp_word(16'h0A3C));
  endtask

  task automatic t_plain_write;
    logic [31:0] d;
    boot(16'h0001);
    wr(2'd1, 32'hFFFF_7FFF);
    chk("R6", "no reboot without bit15", {31'h0, sys_rst}, 32'h0);
    rd(2'd1, d); chk("R5", "sticky readback msb cleared", d, 32'h7FFF_7FFF);
    rd(2'd2, d); chk("R6", "system unchanged", d, exp_word(16'h0001));
    wr(2'd2, 32'h1234_5678);
    wr(2'd0, 32'h1234_5678);
    rd(2'd2, d); chk("R10", "write to system ignored", d, exp_word(16'h0001));
    rd(2'd0, d); chk("R10", "write to pad ignored", d, 32'h0000_0001);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, d); chk("R11", "address 3 reads zero", d, 32'h0);
  endtask

  task automatic t_reboot;
    logic [31:0] d;
    logic [31:0] w;
    int n;
    w = 32'h9AB4_8123;
    boot(16'h0005);
    pad = 16'h7777;
    wr(2'd1, w);
    n = 0;
    while (sys_rst === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R7", "reboot length", n, HOLD);
    rd(2'd1, d); chk("R6", "sticky after reboot", d, w & 32'h7FFF_FFFF);
    rd(2'd2, d); chk("R6", "system after reboot", d, w);
    rd(2'd0, d); chk("R8", "pads not recaptured", d, 32'h0000_0005);
    chk("R9", "skew after reboot", skew_cfg, exp_skew(w));
    chk("R9", "skew_sel after reboot", {30'h0, skew_sel}, {30'h0, w[17:16]});
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_rst !== 1'b0) n++;
    end
    chk("R8", "no second reboot from held bit", n, 0);
  endtask

  task automatic t_write_in_reboot;
    logic [31:0] d;
    int n;
    boot(16'h0000);
    wr(2'd1, 32'h0003_8000);
    repeat (4) @(negedge clk);
    wr(2'd1, 32'h0000_8FFF);
    n = 6;
    while (sys_rst === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R10", "write during reboot no extension", n, HOLD);
    rd(2'd1, d); chk("R10", "sticky unchanged by write in reboot", d, 32'h0003_8000);
    rd(2'd2, d); chk("R10", "system unchanged by write in reboot", d, 32'h0003_8000);
  endtask

  initial begin
    t_reset();
    t_capture(16'h0000, "R2");
    t_capture(16'h1801, "R4");
    t_capture(16'h0AAA, "R4");
    t_capture(16'h7FFF, "R4");
    t_capture(16'h8000, "R3");
    t_capture(16'hE7F0, "R3");
    t_once();
    t_plain_write();
    t_reboot();
    t_write_in_reboot();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule